// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This block takes two binary32 operands and a 3-bit operation code and returns either a compare outcome, the lesser or greater of the two operands, or the first operand with a new sign bit. It is meant to sit beside the arithmetic datapath of a floating-point pipeline. It serves the non-rounding operations, which need NaN screening but no normalisation.

Each accepted input produces one registered result one clock later. The result comes with a valid strobe and an invalid-operation flag. Compares put 0 or 1 in bit 0 of the result and clear every other bit. A NaN is any pattern with an all-ones exponent and a nonzero fraction. It is signaling when fraction bit 22 is clear and quiet when that bit is set.

Top module: `fpcmp_unit`

## Requirements
- R1: For less-than (op 1) and less-or-equal (op 2), a NaN in either operand, quiet or signaling, gives result 0 and raises the invalid flag.
- R2: For equality (op 0), a NaN operand gives result 0. The invalid flag is raised only when one of the operands is a signaling NaN (fraction bit 22 clear); a quiet NaN alone leaves it low.
- R3: For non-NaN operands, compares follow numeric order, and +0 and -0 count as equal: op 0 on +0/-0 returns 1, op 1 on -0,+0 returns 0, op 2 returns 1. Compare results use bit 0 only, with bits 31:1 zero.
- R4: Minimum (op 3) and maximum (op 4) treat -0 (0x80000000) as strictly below +0 (0x00000000), whatever the order of the operands. For other non-NaN operands they return the numerically lesser or greater operand.
- R5: When both operands of op 3 or op 4 are NaN, the result is the canonical NaN 0x7fc00000.
- R6: When exactly one operand of op 3 or op 4 is NaN, the result is the other operand unchanged. A signaling NaN on either side raises the invalid flag, even when the result is a number.
- R7: Sign injection keeps bits 30:0 of operand A. Op 5 takes its sign from B, op 6 from the inverse of B's sign, and op 7 from the XOR of both signs. No flag is raised and NaN payloads pass through unaltered.
- R8: Result and flag appear on the clock edge after an input accepted with in_valid high, and out_valid is high for exactly that cycle. Without in_valid, out_valid is low and result and flag hold their last values.
- R9: While reset is high, out_valid, result and the invalid flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation: 0 eq, 1 lt, 2 le, 3 min, 4 max, 5 sgnj, 6 sgnjn, 7 sgnjx |
| opnd_a | input | 32 | First operand (binary32) |
| opnd_b | input | 32 | Second operand (binary32) |
| out_valid | output | 1 | Result registered from the previous cycle's accepted input |
| result | output | 32 | Compare bit, selected operand, canonical NaN or sign-injected value |
| flag_invalid | output | 1 | Invalid-operation flag for the registered result |

## Verification
The assertions assume that op, opnd_a and opnd_b are stable and meaningful in any cycle where in_valid is high. Their checks on result and flag look back only at the cycle that had in_valid set. The stimulus drives all inputs on the falling edge and raises in_valid for a single cycle per vector. In idle cycles it changes the operands and the op code on purpose, which shows that nothing is registered without in_valid.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    OP_EQ    = 3'd0,
    OP_LT    = 3'd1,
    OP_LE    = 3'd2,
    OP_MIN   = 3'd3,
    OP_MAX   = 3'd4,
    OP_SGNJ  = 3'd5,
    OP_SGNJN = 3'd6,
    OP_SGNJX = 3'd7
  } fpcmp_op_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fpcmp_cls_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]     opnd,
  output fpcmp_pkg::fpcmp_cls_t cls,
  output logic [W-2:0]     mag
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  always_comb begin
    exp_f    = opnd[W-2 -: EXP_W];
    frac_f   = opnd[FRAC_W-1:0];
    exp_ones = &exp_f;
    frac_nz  = |frac_f;
    mag      = opnd[W-2:0];

    cls.sign    = opnd[W-1];
    cls.is_nan  = exp_ones && frac_nz;
    cls.is_snan = exp_ones && frac_nz && !frac_f[FRAC_W-1];
    cls.is_zero = (mag == '0);
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MAG_W = 31
) (
  input  logic             sign_a,
  input  logic             zero_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  logic             zero_b,
  input  logic [MAG_W-1:0] mag_b,
  output logic             ord_lt,
  output logic             ord_eq,
  output logic             tot_lt
);

  logic mag_lt;
  logic mag_gt;
  logic both_zero;

  always_comb begin
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    both_zero = zero_a && zero_b;

    // Total order for min/max: negative zero sits below positive zero.
    unique case ({sign_a, sign_b})
      2'b10:   tot_lt = 1'b1;
      2'b01:   tot_lt = 1'b0;
      2'b00:   tot_lt = mag_lt;
      default: tot_lt = mag_gt;
    endcase

    // Numeric order for compares: the two zeros are equal.
    ord_lt = tot_lt && !both_zero;
    ord_eq = both_zero || ((sign_a == sign_b) && (mag_a == mag_b));
  end

endmodule

// File: rtl/fpcmp_select.sv
module fpcmp_select #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [2:0]            op,
  input  logic [W-1:0]          opnd_a,
  input  logic [W-1:0]          opnd_b,
  input  fpcmp_pkg::fpcmp_cls_t cls_a,
  input  fpcmp_pkg::fpcmp_cls_t cls_b,
  input  logic                  ord_lt,
  input  logic                  ord_eq,
  input  logic                  tot_lt,
  output logic [W-1:0]          res,
  output logic                  nv
);
  import fpcmp_pkg::*;

  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  fpcmp_op_e op_e;
  logic      any_nan;
  logic      any_snan;
  logic      cmp_bit;
  logic      new_sign;
  logic [W-1:0] minmax_val;

  always_comb begin
    op_e     = fpcmp_op_e'(op);
    any_nan  = cls_a.is_nan || cls_b.is_nan;
    any_snan = cls_a.is_snan || cls_b.is_snan;

    cmp_bit  = 1'b0;
    new_sign = cls_b.sign;
    res      = '0;
    nv       = 1'b0;

    if (cls_a.is_nan && cls_b.is_nan) minmax_val = CANON_NAN;
    else if (cls_a.is_nan)           minmax_val = opnd_b;
    else if (cls_b.is_nan)           minmax_val = opnd_a;
    else if (op_e == OP_MIN)         minmax_val = tot_lt ? opnd_a : opnd_b;
    else                             minmax_val = tot_lt ? opnd_b : opnd_a;

    unique case (op_e)
      OP_EQ: begin
        cmp_bit = !any_nan && ord_eq;
        nv      = any_snan;
        res     = {{(W-1){1'b0}}, cmp_bit};
      end
      OP_LT: begin
        cmp_bit = !any_nan && ord_lt;
        nv      = any_nan;
        res     = {{(W-1){1'b0}}, cmp_bit};
      end
      OP_LE: begin
        cmp_bit = !any_nan && (ord_lt || ord_eq);
        nv      = any_nan;
        res     = {{(W-1){1'b0}}, cmp_bit};
      end
      OP_MIN, OP_MAX: begin
        res = minmax_val;
        nv  = any_snan;
      end
      default: begin
        if (op_e == OP_SGNJ)       new_sign = cls_b.sign;
        else if (op_e == OP_SGNJN) new_sign = !cls_b.sign;
        else                       new_sign = cls_a.sign ^ cls_b.sign;
        res = {new_sign, opnd_a[W-2:0]};
        nv  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_invalid
);
  import fpcmp_pkg::*;

  localparam logic [W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] NEG_ZERO = {1'b1, {(W-1){1'b0}}};

  fpcmp_cls_t   cls [2];
  logic [W-2:0] mag [2];
  logic [W-1:0] opnds [2];
  logic ord_lt, ord_eq, tot_lt;
  logic [W-1:0] res_c;
  logic         nv_c;

  assign opnds[0] = opnd_a;
  assign opnds[1] = opnd_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .opnd (opnds[g]),
      .cls  (cls[g]),
      .mag  (mag[g])
    );
  end

  fpcmp_order #(.MAG_W(W-1)) u_ord (
    .sign_a (cls[0].sign),
    .zero_a (cls[0].is_zero),
    .mag_a  (mag[0]),
    .sign_b (cls[1].sign),
    .zero_b (cls[1].is_zero),
    .mag_b  (mag[1]),
    .ord_lt (ord_lt),
    .ord_eq (ord_eq),
    .tot_lt (tot_lt)
  );

  fpcmp_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .op     (op),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .ord_lt (ord_lt),
    .ord_eq (ord_eq),
    .tot_lt (tot_lt),
    .res    (res_c),
    .nv     (nv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= res_c;
        flag_invalid <= nv_c;
      end
    end
  end

  logic a_nan_p, b_nan_p;
  assign a_nan_p = (&opnd_a[W-2 -: EXP_W]) && (|opnd_a[FRAC_W-1:0]);
  assign b_nan_p = (&opnd_b[W-2 -: EXP_W]) && (|opnd_b[FRAC_W-1:0]);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(flag_invalid)); // R8
  AST_ORDERED_NAN_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 3'd1 || op == 3'd2) && (a_nan_p || b_nan_p)
    |=> flag_invalid && result == '0); // R1
  AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid && op <= 3'd2 |=> result[W-1:1] == '0); // R3
  AST_NEG_ZERO_MIN: assert property (@(posedge clk) disable iff (rst)
    in_valid && op == 3'd3 && opnd_a == NEG_ZERO && opnd_b == '0
    |=> result == NEG_ZERO); // R4
  AST_CANON_BOTH_NAN: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == 3'd3 || op == 3'd4) && a_nan_p && b_nan_p
    |=> result == CANON_NAN); // R5
  AST_SGNJ_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && op >= 3'd5 |=> !flag_invalid); // R7
  AST_SGNJ_KEEPS_BODY: assert property (@(posedge clk) disable iff (rst)
    in_valid && op >= 3'd5 |=> result[W-2:0] == $past(opnd_a[W-2:0])); // R7

endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  localparam logic [31:0] P1 = 32'h3f800000, P2 = 32'h40000000;
  localparam logic [31:0] N1 = 32'hbf800000, N2 = 32'hc0000000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN = 32'h7fc00000, SN = 32'h7f800001;
  localparam logic [31:0] QP = 32'h7fc12345, NINF = 32'hff800000;

  always #2.5 clk = ~clk;

  fpcmp_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid)
  );

  task automatic check(string req, logic [31:0] got_r, logic [31:0] exp_r,
                       logic got_f, logic exp_f);
    vectors++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      misses++;
      $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
               req, got_r, got_f, exp_r, exp_f);
    end
  endtask

  task automatic run(string req, logic [2:0] o, logic [31:0] a, logic [31:0] b,
                     logic [31:0] exp_r, logic exp_f);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (out_valid !== 1'b1) begin
      vectors++; misses++;
      $display("FAIL %s: out_valid=%b expected 1", req, out_valid);
    end
    check(req, result, exp_r, flag_invalid, exp_f);
  endtask

  task automatic t_reset;
    check("R9", result, 32'h0, flag_invalid, 1'b0);
    vectors++;
    if (out_valid !== 1'b0) begin
      misses++; $display("FAIL R9: out_valid=%b expected 0", out_valid);
    end
  endtask

  task automatic t_equal;
    run("R3", 3'd0, P1, P1, 32'd1, 1'b0);
    run("R3", 3'd0, PZ, NZ, 32'd1, 1'b0);
    run("R3", 3'd0, P1, N1, 32'd0, 1'b0);
    run("R2", 3'd0, QN, P1, 32'd0, 1'b0);
    run("R2", 3'd0, P1, SN, 32'd0, 1'b1);
  endtask

  task automatic t_order;
    run("R3", 3'd1, P1, P2, 32'd1, 1'b0);
    run("R3", 3'd1, N2, N1, 32'd1, 1'b0);
    run("R3", 3'd1, N1, N2, 32'd0, 1'b0);
    run("R3", 3'd1, NINF, N2, 32'd1, 1'b0);
    run("R3", 3'd1, NZ, PZ, 32'd0, 1'b0);
    run("R3", 3'd2, NZ, PZ, 32'd1, 1'b0);
    run("R3", 3'd2, P2, P1, 32'd0, 1'b0);
    run("R1", 3'd1, QN, P1, 32'd0, 1'b1);
    run("R1", 3'd2, P1, SN, 32'd0, 1'b1);
    run("R1", 3'd2, QN, QN, 32'd0, 1'b1);
  endtask

  task automatic t_minmax;
    run("R4", 3'd3, NZ, PZ, NZ, 1'b0);
    run("R4", 3'd3, PZ, NZ, NZ, 1'b0);
    run("R4", 3'd4, NZ, PZ, PZ, 1'b0);
    run("R4", 3'd4, PZ, NZ, PZ, 1'b0);
    run("R4", 3'd3, P1, N2, N2, 1'b0);
    run("R4", 3'd4, P1, N2, P1, 1'b0);
    run("R4", 3'd3, N1, N2, N2, 1'b0);
  endtask

  task automatic t_minmax_nan;
    run("R5", 3'd3, QN, QN, QN, 1'b0);
    run("R5", 3'd4, SN, QP, QN, 1'b1);
    run("R6", 3'd3, QP, P2, P2, 1'b0);
    run("R6", 3'd4, P2, SN, P2, 1'b1);
    run("R6", 3'd3, N1, QP, N1, 1'b0);
  endtask

  task automatic t_sign_inject;
    run("R7", 3'd5, P1, N2, N1, 1'b0);
    run("R7", 3'd6, P1, N2, P1, 1'b0);
    run("R7", 3'd6, P1, P2, N1, 1'b0);
    run("R7", 3'd7, N1, N2, P1, 1'b0);
    run("R7", 3'd7, N1, P2, N1, 1'b0);
    run("R7", 3'd5, SN, NZ, 32'hff800001, 1'b0);
  endtask

  task automatic t_idle_hold;
    run("R8", 3'd1, QN, P1, 32'd0, 1'b1);
    @(negedge clk);
    op = 3'd4; opnd_a = P2; opnd_b = P1;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      misses++; $display("FAIL R8: out_valid=%b expected 0", out_valid);
    end
    check("R8", result, 32'd0, flag_invalid, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_equal();
    t_order();
    t_minmax();
    t_minmax_nan();
    t_sign_inject();
    t_idle_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

endmodule